// File: doc/BRIEF.md
# Secondary Interface Status Register

This block holds the 16-bit status register that a PCI-to-PCI bridge reports for its secondary bus. The register occupies the upper half (bits 31:16) of its configuration dword. It combines three kinds of content. Some bits are capability flags that are fixed high. One two-bit field gives the decode-timing code. The remaining bits are sticky event flags that record error and abort events seen on the secondary side.

The secondary bus logic reports each event as a one-cycle pulse on its own input, and the matching flag latches high. Software clears a flag by writing a 1 to its bit position through the configuration write port; that byte lane must be enabled. The parity flag only latches while the parity-error-response enable from the command register is high. When an event and a clearing write land on the same flag in the same cycle, the event takes precedence, so no event is lost. The read output always shows the current 16-bit value, with bit 0 of the output corresponding to dword bit 16.

Top module: `secstat_reg`

## Requirements
- R1: After a synchronous reset, every sticky flag is 0 and `rd_data` reads 16'h02A0.
- R2: Reserved positions always read 0. These are dword bits 20:16, 22 and 31, which are `rd_data` bits 4:0, 6 and 15.
- R3: The 66 MHz capability bit (dword 21, `rd_data[5]`) and the fast back-to-back capability bit (dword 23, `rd_data[7]`) always read 1.
- R4: The decode-timing field (dword 26:25, `rd_data[10:9]`) always reads 2'b01.
- R5: The data parity flag (dword 24, `rd_data[8]`) sets one cycle after an `ev_perr` pulse, but only if `perr_resp_en` is 1 in that cycle. A pulse while the enable is 0 leaves the flag unchanged.
- R6: The signaled-target-abort flag (dword 27, `rd_data[11]`) sets one cycle after an `ev_sig_tabort` pulse.
- R7: The received-target-abort flag (dword 28, `rd_data[12]`) sets after `ev_rcv_tabort`. The received-master-abort flag (dword 29, `rd_data[13]`) sets after `ev_rcv_mabort`.
- R8: The system-error flag (dword 30, `rd_data[14]`) sets one cycle after an `ev_serr` pulse.
- R9: A write with `cfg_be[3]`=1 clears, one cycle later, each sticky flag whose `cfg_wdata` bit is 1. Other flags are unchanged.
- R10: If a set event and a clearing write hit the same flag in the same cycle, the flag is 1 afterwards.
- R11: Writing 0 to a flag has no effect. A write with `cfg_be[3]`=0 has no effect. Writes to read-only positions never change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe for this dword |
| cfg_be | input | 4 | Byte enables of the configuration dword |
| cfg_wdata | input | 32 | Configuration write data (full dword) |
| perr_resp_en | input | 1 | Parity-error-response enable from the command register |
| ev_perr | input | 1 | Pulse: secondary parity error observed |
| ev_sig_tabort | input | 1 | Pulse: bridge as secondary target terminated with target abort |
| ev_rcv_tabort | input | 1 | Pulse: bridge-mastered secondary transaction got target abort |
| ev_rcv_mabort | input | 1 | Pulse: bridge-mastered secondary transaction got master abort |
| ev_serr | input | 1 | Pulse: secondary system error asserted |
| rd_data | output | 16 | Register value (dword bits 31:16) |

## Verification
Assertions inside each flag cell check, on every cycle, that a set produces a 1 on the next cycle, that a clear without a set produces a 0, and that a flag with neither holds its value. At the top level an assertion checks that the parity flag never rises while the response enable is low. Only the bench scenarios can show the mapping of each event to its bit position, the byte-lane gating of clears, and the fixed content of the read-only positions. To do this, the bench compares every field of `rd_data` against a behavioural model on every clock.

// File: rtl/secstat_pkg.sv
package secstat_pkg;

    localparam int DWORD_W   = 32;
    localparam int LANE_W    = 8;
    localparam int NUM_LANES = DWORD_W / LANE_W;
    localparam int REG_W     = 16;
    localparam int REG_LSB   = 16;
    localparam int NUM_FLAGS = 5;

    // dword positions of the fixed fields
    localparam int POS_CAP66   = 21;
    localparam int POS_FASTB2B = 23;
    localparam int POS_TIMING  = 25;
    localparam logic [1:0] TIMING_MEDIUM = 2'b01;

    typedef enum int unsigned {
        FLG_PARITY  = 0,
        FLG_SIG_TA  = 1,
        FLG_RCV_TA  = 2,
        FLG_RCV_MA  = 3,
        FLG_SYSERR  = 4
    } flag_idx_e;

    typedef struct packed {
        logic syserr;
        logic rcv_ma;
        logic rcv_ta;
        logic sig_ta;
        logic parity;
    } sec_evt_t;

    // dword bit position of each sticky flag
    function automatic int flag_pos(input int idx);
        case (idx)
            FLG_PARITY: return 24;
            FLG_SIG_TA: return 27;
            FLG_RCV_TA: return 28;
            FLG_RCV_MA: return 29;
            default:    return 30;
        endcase
    endfunction

    function automatic logic [DWORD_W-1:0] w1c_mask();
        logic [DWORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_FLAGS; i++) m[flag_pos(i)] = 1'b1;
        return m;
    endfunction

    function automatic logic [DWORD_W-1:0] lane_expand(input logic [NUM_LANES-1:0] be);
        logic [DWORD_W-1:0] m;
        for (int i = 0; i < DWORD_W; i++) m[i] = be[i / LANE_W];
        return m;
    endfunction

endpackage

// File: rtl/secstat_clear_decode.sv
module secstat_clear_decode
    import secstat_pkg::*;
(
    input  logic                  wr,
    input  logic [NUM_LANES-1:0]  be,
    input  logic [DWORD_W-1:0]    wdata,
    output logic [NUM_FLAGS-1:0]  clr
);
    logic [DWORD_W-1:0] hit;

    always_comb begin
        hit = {DWORD_W{wr}} & lane_expand(be) & wdata & w1c_mask();
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_clr
        localparam int POS = flag_pos(g);
        assign clr[g] = hit[POS];
    end
endmodule

// File: rtl/secstat_w1c_bit.sv
module secstat_w1c_bit (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (set)  q <= 1'b1;
        else if (clr)  q <= 1'b0;
    end

    // R10: an event wins over a clear in the same cycle
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        set |=> q);
    // R9: a clear with no event empties the flag
    assert_clear_takes_R9: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !q);
    // R11: without event or clear the flag holds
    assert_flag_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (!clr && !set) |=> $stable(q));
endmodule

// File: rtl/secstat_read_fmt.sv
module secstat_read_fmt
    import secstat_pkg::*;
(
    input  logic [NUM_FLAGS-1:0] flags,
    output logic [REG_W-1:0]     value
);
    logic [DWORD_W-1:0] dw;

    always_comb begin
        dw = '0;
        dw[POS_CAP66]                = 1'b1;
        dw[POS_FASTB2B]              = 1'b1;
        dw[POS_TIMING +: 2]          = TIMING_MEDIUM;
        for (int i = 0; i < NUM_FLAGS; i++) dw[flag_pos(i)] = flags[i];
        value = dw[REG_LSB +: REG_W];
    end
endmodule

// File: rtl/secstat_reg.sv
module secstat_reg
    import secstat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    input  logic        perr_resp_en,
    input  logic        ev_perr,
    input  logic        ev_sig_tabort,
    input  logic        ev_rcv_tabort,
    input  logic        ev_rcv_mabort,
    input  logic        ev_serr,
    output logic [15:0] rd_data
);
    sec_evt_t             evt;
    logic [NUM_FLAGS-1:0] set_v;
    logic [NUM_FLAGS-1:0] clr_v;
    logic [NUM_FLAGS-1:0] flag_q;

    always_comb begin
        evt.parity = ev_perr & perr_resp_en;
        evt.sig_ta = ev_sig_tabort;
        evt.rcv_ta = ev_rcv_tabort;
        evt.rcv_ma = ev_rcv_mabort;
        evt.syserr = ev_serr;
        set_v      = evt;
    end

    secstat_clear_decode u_clr (
        .wr    (cfg_wr),
        .be    (cfg_be),
        .wdata (cfg_wdata),
        .clr   (clr_v)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        secstat_w1c_bit u_bit (
            .clk (clk),
            .rst (rst),
            .set (set_v[g]),
            .clr (clr_v[g]),
            .q   (flag_q[g])
        );
    end

    secstat_read_fmt u_fmt (
        .flags (flag_q),
        .value (rd_data)
    );

    // R5: parity flag cannot rise unless the response enable qualified the pulse
    assert_parity_gated_R5: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[8] && !(ev_perr && perr_resp_en)) |=> !rd_data[8]);
    // R8: a system error pulse shows in the read value next cycle
    assert_syserr_seen_R8: assert property (@(posedge clk) disable iff (rst)
        ev_serr |=> rd_data[14]);
endmodule

// File: tb/secstat_reg_test.sv
module secstat_reg_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        perr_resp_en;
    logic        ev_perr, ev_sig_tabort, ev_rcv_tabort, ev_rcv_mabort, ev_serr;
    logic [15:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    secstat_reg uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .perr_resp_en(perr_resp_en),
        .ev_perr(ev_perr), .ev_sig_tabort(ev_sig_tabort),
        .ev_rcv_tabort(ev_rcv_tabort), .ev_rcv_mabort(ev_rcv_mabort),
        .ev_serr(ev_serr), .rd_data(rd_data)
    );

    // behavioural reference of the five sticky flags
    bit m_par, m_sta, m_rta, m_rma, m_ser;

    always @(posedge clk) begin
        bit wipe;
        wipe = cfg_wr && cfg_be[3];
        if (rst) begin
            m_par <= 0; m_sta <= 0; m_rta <= 0; m_rma <= 0; m_ser <= 0;
        end else begin
            if (ev_perr && perr_resp_en) m_par <= 1;
            else if (wipe && cfg_wdata[24]) m_par <= 0;
            if (ev_sig_tabort) m_sta <= 1;
            else if (wipe && cfg_wdata[27]) m_sta <= 0;
            if (ev_rcv_tabort) m_rta <= 1;
            else if (wipe && cfg_wdata[28]) m_rta <= 0;
            if (ev_rcv_mabort) m_rma <= 1;
            else if (wipe && cfg_wdata[29]) m_rma <= 0;
            if (ev_serr) m_ser <= 1;
            else if (wipe && cfg_wdata[30]) m_ser <= 0;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R2 reserved", int'({rd_data[15], rd_data[6], rd_data[4:0]}), 0);
        check("R3 capability", int'({rd_data[7], rd_data[5]}), 3);
        check("R4 timing", int'(rd_data[10:9]), 1);
        check("R5 parity flag", int'(rd_data[8]), int'(m_par));
        check("R6 sig target abort", int'(rd_data[11]), int'(m_sta));
        check("R7 rcv target abort", int'(rd_data[12]), int'(m_rta));
        check("R7 rcv master abort", int'(rd_data[13]), int'(m_rma));
        check("R8 system error", int'(rd_data[14]), int'(m_ser));
    endtask

    task automatic idle();
        cfg_wr = 0; cfg_be = 0; cfg_wdata = 0;
        ev_perr = 0; ev_sig_tabort = 0; ev_rcv_tabort = 0;
        ev_rcv_mabort = 0; ev_serr = 0;
    endtask

    // inputs were set after a falling edge; step past the rising edge and compare
    task automatic step();
        @(negedge clk);
        if (!rst) compare_all();
        idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle();
        perr_resp_en = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 reset value", int'(rd_data), 'h02A0);
        step();

        // R5: pulse with enable low is ignored
        ev_perr = 1; perr_resp_en = 0; step();
        check("R5 gated off", int'(rd_data[8]), 0);
        ev_perr = 1; perr_resp_en = 1; step();
        check("R5 set", int'(rd_data[8]), 1);

        ev_sig_tabort = 1; step();
        check("R6 set", int'(rd_data[11]), 1);
        ev_rcv_tabort = 1; ev_rcv_mabort = 1; step();
        check("R7 both set", int'(rd_data[13:12]), 3);
        ev_serr = 1; step();
        check("R8 set", int'(rd_data[14]), 1);

        // R11: lane 3 disabled, and zero data, and read-only positions
        cfg_wr = 1; cfg_be = 4'b0111; cfg_wdata = '1; step();
        check("R11 lane off", int'(rd_data), 'h7BA0);
        cfg_wr = 1; cfg_be = 4'b1111; cfg_wdata = 32'h0; step();
        check("R11 write zero", int'(rd_data), 'h7BA0);
        cfg_wr = 1; cfg_be = 4'b1111; cfg_wdata = 32'h81FF_FFFF; step();
        check("R11 ro bits", int'(rd_data), 'h7AA0);

        // R9: selective clear
        cfg_wr = 1; cfg_be = 4'b1000; cfg_wdata = 32'h1800_0000; step();
        check("R9 selective", int'(rd_data), 'h62A0);

        // R10: set and clear collide
        ev_serr = 1; cfg_wr = 1; cfg_be = 4'b1000; cfg_wdata = 32'h6000_0000; step();
        check("R10 set wins", int'(rd_data[14:13]), 2);
        cfg_wr = 1; cfg_be = 4'b1000; cfg_wdata = 32'h7F00_0000; step();
        check("R9 clear all", int'(rd_data), 'h02A0);

        for (int i = 0; i < 2000; i++) begin
            int unsigned r;
            r = $urandom;
            ev_perr       = (r[2:0] == 0);
            ev_sig_tabort = (r[5:3] == 0);
            ev_rcv_tabort = (r[8:6] == 0);
            ev_rcv_mabort = (r[11:9] == 0);
            ev_serr       = (r[14:12] == 0);
            perr_resp_en  = r[15];
            cfg_wr        = (r[17:16] == 0);
            cfg_be        = r[21:18];
            cfg_wdata     = $urandom;
            step();
        end
        finish_run();
    end
endmodule